// File: doc/BRIEF.md
# Multi-Channel Timer Register Unit

This block is the register front end for a group of timer channels. It sits on a simple byte-addressed register bus and decodes each access. An access goes to one of three targets: a one-bit output-control register, a start register, or the register window of one channel. The counters themselves live outside the block. The unit gives them a per-channel write strobe, a per-channel read strobe, a window-relative byte offset and the write data. It returns their read data one cycle later. Each channel's run input comes from one bit of the start register, so software can start and stop every channel on its own. Each channel keeps its own interrupt line.

Two build options control the configuration. `HAS_CH2` adds a third channel, the one that carries the capture register, so its window is one word longer than the others. `HAS_OUTCTL` adds the output-control register at offset zero. An access that falls on no target returns zero and raises an error pulse. A start write that sets a bit for a channel that does not exist is refused and also raises the error pulse.

Top module: `tmu_unit`

## Requirements
- R1: After reset, `bus_rdata`, `bus_err`, `out_ctl` and every `chan_run` bit are zero.
- R2: With `HAS_OUTCTL`=1, a write to byte offsets 0x00..0x03 stores only bit 0 of the write data. That bit drives `out_ctl` from the next edge on, and a read at those offsets returns it in bit 0 with zeros above.
- R3: A write to byte offsets 0x04..0x07 that sets no bit at index NCH or above is stored. Bit n then drives `chan_run[n]` from the edge that ends the write (1 runs, 0 stops and holds the count). A read of that offset returns the stored value, zero-extended.
- R4: Channel windows start at 0x08 (12 bytes), 0x14 (12 bytes) and 0x20 (16 bytes, only with `HAS_CH2`=1). During an access inside a window, the unit raises exactly that channel's strobe in the same cycle. It drives `chan_off` with the address minus the window base, and `chan_wdata` with the bus data.
- R5: Read data for any mapped offset appears on `bus_rdata` in the cycle after the read is presented. For a channel, this is the value the channel drove on its `chan_rdata` slice.
- R6: An access to an unmapped offset raises `bus_err` for one cycle, one cycle after the access. It returns zero on `bus_rdata`, raises no channel strobe, and a write there changes neither `out_ctl` nor `chan_run`.
- R7: With `HAS_CH2`=0, offsets 0x20 and above are unmapped, and the unit has two channel strobes and two run bits.
- R8: A start write that sets any bit at index NCH or above (bit 2 in the two-channel build) leaves the start register and `chan_run` unchanged and raises `bus_err` one cycle later.
- R9: With `HAS_OUTCTL`=0, offsets 0x00..0x03 are unmapped.
- R10: At most one channel strobe, read or write, is high in any cycle. A write strobe never rises without `bus_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle (ignored when `bus_wr` is high) |
| bus_addr | input | ADDR_W | Byte address within the unit |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle error pulse, one cycle after a bad access |
| out_ctl | output | 1 | Stored output-control bit |
| chan_run | output | NCH | Run level per channel |
| chan_wr | output | NCH | Per-channel write strobe |
| chan_rd | output | NCH | Per-channel read strobe |
| chan_off | output | 4 | Byte offset inside the selected window |
| chan_wdata | output | DATA_W | Write data forwarded to channels |
| chan_rdata | input | NCH*DATA_W | Read data from each channel, channel 0 in the low slice |

## Verification
The assertions check several properties on every cycle:
- The run bits load only from a legal start write and otherwise hold.
- The output-control bit changes only after a write at offset zero.
- The channel strobes are never more than one-hot.
- The read data is zero whenever the error pulse is high.

Only the bench's scenarios can show the rest. The address map is one such property: each window base and span, and the offset subtraction. The read data of each target, the refusal of an illegal start bit, and the difference between the full and the reduced build also need the bench. It shows these by sweeping every byte address for reads and writes on both builds.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

   typedef enum logic [1:0] {
      HIT_NONE,
      HIT_OUTCTL,
      HIT_START,
      HIT_CHAN
   } hit_e;

   localparam int WIN_OFF_W = 4;

   typedef struct packed {
      hit_e                 kind;
      logic [1:0]           idx;
      logic [WIN_OFF_W-1:0] off;
   } dec_t;

   // Window placement: two short windows, then a longer one with capture.
   function automatic int win_base(input int i);
      return 8 + 12 * i;
   endfunction

   function automatic int win_span(input int i);
      return (i == 2) ? 16 : 12;
   endfunction

endpackage

// File: rtl/tmu_addr_decode.sv
module tmu_addr_decode
   import tmu_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NCH        = 3,
   parameter bit HAS_OUTCTL = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   assign word = addr[ADDR_W-1:2];

   always_comb begin
      dec.kind = HIT_NONE;
      dec.idx  = '0;
      dec.off  = '0;
      if (HAS_OUTCTL && word == '0) begin
         dec.kind = HIT_OUTCTL;
      end else if (word == WORD_W'(1)) begin
         dec.kind = HIT_START;
      end
      for (int i = 0; i < NCH; i++) begin
         if (int'(addr) >= win_base(i) && int'(addr) < win_base(i) + win_span(i)) begin
            dec.kind = HIT_CHAN;
            dec.idx  = 2'(i);
            dec.off  = WIN_OFF_W'(int'(addr) - win_base(i));
         end
      end
   end

endmodule

// File: rtl/tmu_ctrl_regs.sv
module tmu_ctrl_regs #(
   parameter int NCH    = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_outctl,
   input  logic              wr_start,
   input  logic [DATA_W-1:0] wdata,
   output logic              start_bad,
   output logic              outctl_q,
   output logic [NCH-1:0]    start_q
);

   // Any bit addressing a channel that was not built makes the write illegal.
   assign start_bad = |(wdata >> NCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outctl_q <= 1'b0;
         start_q  <= '0;
      end else begin
         if (wr_outctl) outctl_q <= wdata[0];
         if (wr_start && !start_bad) start_q <= wdata[NCH-1:0];
      end
   end

endmodule

// File: rtl/tmu_unit.sv
module tmu_unit
   import tmu_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter bit HAS_CH2    = 1'b1,
   parameter bit HAS_OUTCTL = 1'b1,
   localparam int NCH       = HAS_CH2 ? 3 : 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  bus_err,
   output logic                  out_ctl,
   output logic [NCH-1:0]        chan_run,
   output logic [NCH-1:0]        chan_wr,
   output logic [NCH-1:0]        chan_rd,
   output logic [WIN_OFF_W-1:0]  chan_off,
   output logic [DATA_W-1:0]     chan_wdata,
   input  logic [NCH*DATA_W-1:0] chan_rdata
);

   if (ADDR_W < 6) begin : g_chk_addr
      $error("tmu_unit: ADDR_W must cover the whole map (>= 6)");
   end
   if (DATA_W < NCH) begin : g_chk_data
      $error("tmu_unit: DATA_W must hold one start bit per channel");
   end

   dec_t              dec;
   logic              rd_go;
   logic              start_bad;
   logic              outctl_q;
   logic [NCH-1:0]    start_q;
   logic [DATA_W-1:0] rd_sel;
   logic              err_d;

   assign rd_go = bus_rd && !bus_wr;

   tmu_addr_decode #(
      .ADDR_W     (ADDR_W),
      .NCH        (NCH),
      .HAS_OUTCTL (HAS_OUTCTL)
   ) i_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   tmu_ctrl_regs #(
      .NCH    (NCH),
      .DATA_W (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_outctl (bus_wr && dec.kind == HIT_OUTCTL),
      .wr_start  (bus_wr && dec.kind == HIT_START),
      .wdata     (bus_wdata),
      .start_bad (start_bad),
      .outctl_q  (outctl_q),
      .start_q   (start_q)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_strobe
      assign chan_wr[g] = bus_wr && dec.kind == HIT_CHAN && dec.idx == 2'(g);
      assign chan_rd[g] = rd_go  && dec.kind == HIT_CHAN && dec.idx == 2'(g);
   end

   assign chan_off   = dec.off;
   assign chan_wdata = bus_wdata;
   assign chan_run   = start_q;
   assign out_ctl    = outctl_q;

   always_comb begin
      case (dec.kind)
         HIT_OUTCTL: rd_sel = DATA_W'(outctl_q);
         HIT_START:  rd_sel = DATA_W'(start_q);
         HIT_CHAN:   rd_sel = chan_rdata[int'(dec.idx)*DATA_W +: DATA_W];
         default:    rd_sel = '0;
      endcase
   end

   assign err_d = ((bus_wr || bus_rd) && dec.kind == HIT_NONE)
                || (bus_wr && dec.kind == HIT_START && start_bad);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= rd_go ? rd_sel : '0;
         bus_err   <= err_d;
      end
   end

endmodule

// File: rtl/tmu_unit_chk.sv
module tmu_unit_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int NCH    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-3:0] word,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic              out_ctl,
   input logic [NCH-1:0]    chan_run,
   input logic [NCH-1:0]    chan_wr,
   input logic [NCH-1:0]    chan_rd
);

   logic start_wr;
   logic start_ok;
   assign start_wr = bus_wr && word == (ADDR_W-2)'(1);
   assign start_ok = (bus_wdata >> NCH) == '0;

   a_r3_run_load: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr && start_ok |=> chan_run == $past(bus_wdata[NCH-1:0]));

   a_r8_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_wr && start_ok) |=> $stable(chan_run));

   a_r2_outctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && word == '0) |=> $stable(out_ctl));

   a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({chan_wr, chan_rd}));

   a_r10_wr_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |-> chan_wr == '0);

   a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_rdata == '0);

endmodule

bind tmu_unit tmu_unit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NCH    (NCH)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .word      (bus_addr[ADDR_W-1:2]),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .out_ctl   (out_ctl),
   .chan_run  (chan_run),
   .chan_wr   (chan_wr),
   .chan_rd   (chan_rd)
);

// File: tb/test_tmu_unit.sv
`timescale 1ns/1ps
module test_tmu_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   // Full build: three channels, output-control present.
   logic [31:0] rdata_f;
   logic        err_f, oc_f;
   logic [2:0]  run_f, wr_f, rd_f;
   logic [3:0]  off_f;
   logic [31:0] wd_f;
   logic [95:0] crd_f;

   // Reduced build: two channels, no output-control.
   logic [31:0] rdata_s;
   logic        err_s, oc_s;
   logic [1:0]  run_s, wr_s, rd_s;
   logic [3:0]  off_s;
   logic [31:0] wd_s;
   logic [63:0] crd_s;

   for (genvar g = 0; g < 3; g++) begin : g_mf
      assign crd_f[g*32 +: 32] = {16'h5A00, 8'(g), 4'h0, off_f};
   end
   for (genvar g = 0; g < 2; g++) begin : g_ms
      assign crd_s[g*32 +: 32] = {16'h6B00, 8'(g), 4'h0, off_s};
   end

   tmu_unit i_tmu_unit (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_f),
      .bus_err(err_f), .out_ctl(oc_f), .chan_run(run_f), .chan_wr(wr_f),
      .chan_rd(rd_f), .chan_off(off_f), .chan_wdata(wd_f), .chan_rdata(crd_f)
   );

   tmu_unit #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) i_tmu_unit_lite (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s),
      .bus_err(err_s), .out_ctl(oc_s), .chan_run(run_s), .chan_wr(wr_s),
      .chan_rd(rd_s), .chan_off(off_s), .chan_wdata(wd_s), .chan_rdata(crd_s)
   );

   // Bench-side state models.
   logic       m_oc  [2];
   logic [2:0] m_run [2];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // kind: 0 none, 1 outctl, 2 start, 3 channel
   function automatic void decode_exp(input int a, input bit full,
                                      output int kind, output int idx, output int off);
      kind = 0; idx = 0; off = 0;
      if (a < 4) begin
         if (full) kind = 1;
      end else if (a < 8) kind = 2;
      else if (a < 20) begin kind = 3; idx = 0; off = a - 8; end
      else if (a < 32) begin kind = 3; idx = 1; off = a - 20; end
      else if (a < 48 && full) begin kind = 3; idx = 2; off = a - 32; end
   endfunction

   function automatic logic [2:0] get_rd(input int d);
      return (d == 0) ? rd_f : {1'b0, rd_s};
   endfunction
   function automatic logic [2:0] get_wr(input int d);
      return (d == 0) ? wr_f : {1'b0, wr_s};
   endfunction
   function automatic logic [2:0] get_run(input int d);
      return (d == 0) ? run_f : {1'b0, run_s};
   endfunction

   task automatic do_read(input int a);
      int kind, idx, off;
      logic [31:0] exp;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 8'(a);
      #1;
      for (int d = 0; d < 2; d++) begin
         decode_exp(a, d == 0, kind, idx, off);
         chk(get_rd(d) == ((kind == 3) ? 3'(1 << idx) : 3'b0),
             (kind == 0) ? "R6 rd strobe" : "R4 rd strobe", 32'(get_rd(d)), 32'(a));
         chk(get_wr(d) == 3'b0, "R10 no wr on read", 32'(get_wr(d)), 0);
         if (kind == 3)
            chk(((d == 0) ? off_f : off_s) == 4'(off), "R4 offset",
                32'((d == 0) ? off_f : off_s), 32'(off));
      end
      @(negedge clk);
      bus_rd = 1'b0;
      for (int d = 0; d < 2; d++) begin
         decode_exp(a, d == 0, kind, idx, off);
         case (kind)
            1: exp = 32'(m_oc[d]);
            2: exp = 32'(m_run[d]);
            3: exp = (d == 0) ? {16'h5A00, 8'(idx), 4'h0, 4'(off)}
                              : {16'h6B00, 8'(idx), 4'h0, 4'(off)};
            default: exp = 32'h0;
         endcase
         chk(((d == 0) ? rdata_f : rdata_s) == exp,
             (kind == 0) ? ((d == 1 && a < 4) ? "R9 read" : ((d == 1 && a >= 32) ? "R7 read" : "R6 read"))
                         : ((kind == 1) ? "R2 read" : ((kind == 2) ? "R3 read" : "R5 read")),
             (d == 0) ? rdata_f : rdata_s, exp);
         chk(((d == 0) ? err_f : err_s) == (kind == 0), "R6 read err",
             32'((d == 0) ? err_f : err_s), 32'(kind == 0));
      end
   endtask

   task automatic do_write(input int a, input logic [31:0] data);
      int kind, idx, off;
      bit bad;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = data;
      #1;
      for (int d = 0; d < 2; d++) begin
         decode_exp(a, d == 0, kind, idx, off);
         chk(get_wr(d) == ((kind == 3) ? 3'(1 << idx) : 3'b0), "R4 wr strobe", 32'(get_wr(d)), 32'(a));
         chk(get_rd(d) == 3'b0, "R10 no rd on write", 32'(get_rd(d)), 0);
         if (kind == 3) begin
            chk(((d == 0) ? off_f : off_s) == 4'(off), "R4 wr offset",
                32'((d == 0) ? off_f : off_s), 32'(off));
            chk(((d == 0) ? wd_f : wd_s) == data, "R4 wdata", (d == 0) ? wd_f : wd_s, data);
         end
      end
      @(negedge clk);
      bus_wr = 1'b0;
      for (int d = 0; d < 2; d++) begin
         int nch;
         nch = (d == 0) ? 3 : 2;
         decode_exp(a, d == 0, kind, idx, off);
         bad = (kind == 0) || (kind == 2 && (data >> nch) != 0);
         if (kind == 1) m_oc[d] = data[0];
         if (kind == 2 && !bad) m_run[d] = 3'(data & ((1 << nch) - 1));
         chk(((d == 0) ? err_f : err_s) == bad, (kind == 2) ? "R8 start err" : "R6 write err",
             32'((d == 0) ? err_f : err_s), 32'(bad));
         chk(((d == 0) ? oc_f : oc_s) == m_oc[d], "R2 out_ctl",
             32'((d == 0) ? oc_f : oc_s), 32'(m_oc[d]));
         chk(get_run(d) == m_run[d], (kind == 2 && bad) ? "R8 run kept" : "R3 run",
             32'(get_run(d)), 32'(m_run[d]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_oc[0] = 1'b0; m_oc[1] = 1'b0;
      m_run[0] = '0;  m_run[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state on both builds
      chk(rdata_f == 0 && rdata_s == 0, "R1 rdata", rdata_f | rdata_s, 0);
      chk(!err_f && !err_s, "R1 err", 32'({err_f, err_s}), 0);
      chk(!oc_f && !oc_s, "R1 out_ctl", 32'({oc_f, oc_s}), 0);
      chk(run_f == 0 && run_s == 0, "R1 run", 32'({run_f, run_s}), 0);

      // Read sweep over every byte address (R4, R5, R6, R7, R9)
      for (int a = 0; a < 256; a++) do_read(a);

      // Write sweep: data derived from the address, so offsets 4..7
      // exercise start values 100..111 (illegal bit 2 on the reduced build)
      for (int a = 0; a < 256; a++) do_write(a, 32'(a) | ((a >= 8) ? 32'hC300_0000 : 32'h0));

      // R3/R8 directed: legal two-bit start on both, then illegal bit 2 on reduced build
      do_write(4, 32'h3);
      do_write(4, 32'h4);
      do_write(6, 32'h0);
      do_write(5, 32'h1);
      do_write(4, 32'h8);
      // R2: clearing and setting the control bit
      do_write(0, 32'hFFFF_FFFE);
      do_write(2, 32'h0000_0001);

      // Read sweep again with the changed register state
      for (int a = 0; a < 64; a++) do_read(a);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule